// File: doc/BRIEF.md
# Byte-wide EPROM mode controller

This block is a clocked behavioural model of a small electrically erasable read-only memory with a byte-wide data path. On every cycle it looks at three active-low control pins: chip select, output gate and write strobe. It combines them with two encoded supply-level inputs. One input gives the level of the programming supply. The other gives the level of the high-voltage address pin. From these it picks one operating mode: standby, read, output off, byte program, program check, bulk erase, erase check, maker or device code, or inhibit. Levels are carried as small codes, and analog behaviour and access delays are not modelled.

A write only clears bits and a bulk erase only sets them. Both act on a fresh high-to-low transition of the write strobe, as seen at a rising clock edge, and their effect shows from the next cycle. The data bus is split into an input, an output and a drive qualifier that stands in for the three-state buffer. A combination that no mode accepts is flagged on a separate output. Such a combination leaves the array and the bus untouched.

Supply code `vppLevel`: 0 normal, 1 program level, 2 erase level, 3 reserved. Pin code `a9Level`: 0 logic level, 1 identifier level, 2 erase level, 3 reserved. `addr[0]` selects between the two identifier codes.

Top module: `eprom_mode_ctl`

## Requirements
- R1: After reset every byte of the array reads FF hex.
- R2: With `chipEnN` high, `dataDrive` is 0, `dataOut` is 00 and `illegalCombo` is 0, whatever the other inputs are. A strobe pulse under program or erase levels changes no byte in this state.
- R3: Read mode is `chipEnN`=0, `outEnN`=0, `vppLevel`=0 and `a9Level`=0. In it, `dataDrive`=1 and `dataOut` shows the byte at `addr` in the same cycle. With `outEnN`=1, `vppLevel`=0 and `a9Level` 0 or 1, nothing is driven (`dataDrive`=0, `dataOut`=00).
- R4: Program mode is `chipEnN`=0, `outEnN`=1, `vppLevel`=1 and `a9Level`=0. A strobe sampled low after being sampled high stores (old byte AND `dataIn`) at `addr`, and the new value is visible from the next cycle. Nothing is driven in program mode.
- R5: Program check is `chipEnN`=0, `outEnN`=0, `progStrobeN`=1, `vppLevel`=1 and `a9Level`=0. It drives the byte at `addr`.
- R6: Bulk erase needs `chipEnN`=0, `outEnN`=1, `vppLevel`=2, `a9Level`=2, `addr`=0 and `dataIn`=FF hex. A strobe falling edge in this state sets every byte to FF hex from the next cycle.
- R7: Erase check is `chipEnN`=0, `outEnN`=0, `progStrobeN`=1, `vppLevel`=2 and `a9Level` 0 or 2. It drives the byte at `addr`.
- R8: Identifier mode is `chipEnN`=0, `outEnN`=0, `vppLevel`=0 and `a9Level`=1. It drives DA hex when `addr[0]`=0 and 01 hex when `addr[0]`=1.
- R9: With `chipEnN`=0, any other combination raises `illegalCombo`, drives nothing and changes no byte. This covers a reserved code on either level input, `a9Level` 2 with `vppLevel` 0, `a9Level` not 0 with `vppLevel` 1, `a9Level` 1 with `vppLevel` 2, a raised supply with `outEnN`=0 and the strobe low, and erase levels with `outEnN`=1 but a non-zero `addr` or a `dataIn` other than FF hex.
- R10: A strobe held low writes once. A strobe that is already low when program mode is entered writes nothing until it has been sampled high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; array to all ones |
| chipEnN | input | 1 | Active-low chip select |
| outEnN | input | 1 | Active-low output gate |
| progStrobeN | input | 1 | Active-low program / erase strobe |
| addr | input | ADDR_W | Byte address; bit 0 also picks the identifier code |
| dataIn | input | 8 | Data presented to the device |
| vppLevel | input | 2 | Programming supply level code |
| a9Level | input | 2 | High-voltage address pin level code |
| dataOut | output | 8 | Data driven by the device, 00 when not driving |
| dataDrive | output | 1 | 1 when the device drives the bus |
| illegalCombo | output | 1 | 1 when the selected input combination matches no mode |

## Verification
Mode decode, bus drive, the identifier codes and the illegal flag are combinational. They are due in the same cycle that the pins change. A byte write or a bulk erase lands at the rising edge that first samples the strobe low, and it is due on the outputs in the cycle after that edge. The bench applies each vector on the falling edge and compares all three outputs 5 ns later, against a model that holds the array state up to the last rising edge. The model then advances its array and strobe history at the next rising edge. This keeps every comparison one register stage behind any write, exactly as the design is.

// File: rtl/eprom_pkg.sv
`timescale 1ns/1ps
package eprom_pkg;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] MFR_CODE = 8'hDA;
  localparam logic [DATA_W-1:0] DEV_CODE = 8'h01;
  localparam logic [DATA_W-1:0] BLANK_BYTE = {DATA_W{1'b1}};

  typedef enum logic [1:0] {
    VPP_NORM  = 2'd0,
    VPP_PROG  = 2'd1,
    VPP_ERASE = 2'd2,
    VPP_RSVD  = 2'd3
  } vppLvl_t;

  typedef enum logic [1:0] {
    A9_NORM  = 2'd0,
    A9_ID    = 2'd1,
    A9_ERASE = 2'd2,
    A9_RSVD  = 2'd3
  } a9Lvl_t;

  typedef enum logic [3:0] {
    MODE_STANDBY,
    MODE_READ,
    MODE_DISABLE,
    MODE_PROGRAM,
    MODE_PVERIFY,
    MODE_ERASE,
    MODE_EVERIFY,
    MODE_IDENT,
    MODE_ILLEGAL
  } mode_t;

  // Strobes from the mode decoder to the array datapath
  typedef struct packed {
    logic driveArray;
    logic driveIdent;
    logic writeByte;
    logic eraseAll;
    logic illegal;
  } ctlStrobe_t;
endpackage

// File: rtl/eprom_mode_decode.sv
`timescale 1ns/1ps
module eprom_mode_decode
  import eprom_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipEnN,
  input  logic       outEnN,
  input  logic       progStrobeN,
  input  logic       addrZero,
  input  logic       dataAllOnes,
  input  logic [1:0] vppLevel,
  input  logic [1:0] a9Level,
  output ctlStrobe_t strobes
);
  vppLvl_t vpp;
  a9Lvl_t  a9;
  mode_t   mode;
  logic    strobePrevN;
  logic    strobeFall;

  assign vpp = vppLvl_t'(vppLevel);
  assign a9  = a9Lvl_t'(a9Level);

  // Strobe history: a write needs the strobe seen high on the previous edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobePrevN <= 1'b1;
    else       strobePrevN <= progStrobeN;
  end

  assign strobeFall = strobePrevN & ~progStrobeN;

  always_comb begin
    mode = MODE_ILLEGAL;
    if (chipEnN) begin
      mode = MODE_STANDBY;
    end else begin
      case (vpp)
        VPP_NORM: begin
          case (a9)
            A9_NORM: mode = outEnN ? MODE_DISABLE : MODE_READ;
            A9_ID:   mode = outEnN ? MODE_DISABLE : MODE_IDENT;
            default: mode = MODE_ILLEGAL;
          endcase
        end
        VPP_PROG: begin
          if (a9 == A9_NORM) begin
            if (outEnN)           mode = MODE_PROGRAM;
            else if (progStrobeN) mode = MODE_PVERIFY;
          end
        end
        VPP_ERASE: begin
          if (outEnN) begin
            if (a9 == A9_ERASE && addrZero && dataAllOnes) mode = MODE_ERASE;
          end else if (progStrobeN && (a9 == A9_NORM || a9 == A9_ERASE)) begin
            mode = MODE_EVERIFY;
          end
        end
        default: mode = MODE_ILLEGAL;
      endcase
    end
  end

  always_comb begin
    strobes.driveArray = (mode == MODE_READ) || (mode == MODE_PVERIFY) ||
                         (mode == MODE_EVERIFY);
    strobes.driveIdent = (mode == MODE_IDENT);
    strobes.writeByte  = (mode == MODE_PROGRAM) && strobeFall;
    strobes.eraseAll   = (mode == MODE_ERASE) && strobeFall;
    strobes.illegal    = (mode == MODE_ILLEGAL);
  end
endmodule

// File: rtl/eprom_array_path.sv
`timescale 1ns/1ps
module eprom_array_path
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic              addrZero,
  output logic              dataAllOnes,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] cells;

  assign addrZero    = (addr == '0);
  assign dataAllOnes = &dataIn;

  // Program clears bits only; erase sets every byte at once
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cells <= {DEPTH{BLANK_BYTE}};
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobes.eraseAll)
          cells[i] <= BLANK_BYTE;
        else if (strobes.writeByte && addr == ADDR_W'(i))
          cells[i] <= cells[i] & dataIn;
      end
    end
  end

  always_comb begin
    dataDrive = strobes.driveArray | strobes.driveIdent;
    if (strobes.driveIdent)
      dataOut = addr[0] ? DEV_CODE : MFR_CODE;
    else if (strobes.driveArray)
      dataOut = cells[addr];
    else
      dataOut = '0;
  end
endmodule

// File: rtl/eprom_mode_ctl.sv
`timescale 1ns/1ps
module eprom_mode_ctl
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              progStrobeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic [1:0]        vppLevel,
  input  logic [1:0]        a9Level,
  output logic [7:0]        dataOut,
  output logic              dataDrive,
  output logic              illegalCombo
);
  ctlStrobe_t strobes;
  logic       addrZero;
  logic       dataAllOnes;

  eprom_mode_decode decode_i (
    .clk         (clk),
    .rstN        (rstN),
    .chipEnN     (chipEnN),
    .outEnN      (outEnN),
    .progStrobeN (progStrobeN),
    .addrZero    (addrZero),
    .dataAllOnes (dataAllOnes),
    .vppLevel    (vppLevel),
    .a9Level     (a9Level),
    .strobes     (strobes)
  );

  eprom_array_path #(.ADDR_W(ADDR_W)) path_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .addr        (addr),
    .dataIn      (dataIn),
    .addrZero    (addrZero),
    .dataAllOnes (dataAllOnes),
    .dataOut     (dataOut),
    .dataDrive   (dataDrive)
  );

  assign illegalCombo = strobes.illegal;
endmodule

// File: rtl/eprom_mode_ctl_chk.sv
`timescale 1ns/1ps
module eprom_mode_ctl_chk
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipEnN,
  input logic              outEnN,
  input logic              progStrobeN,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dataIn,
  input logic [1:0]        vppLevel,
  input logic [1:0]        a9Level,
  input logic [7:0]        dataOut,
  input logic              dataDrive,
  input logic              illegalCombo
);
  logic [1:0] ageCnt;
  logic       strobeHiPrev;
  logic       readNow, pvNow, progPulse, erasePulse, identNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ageCnt       <= 2'd0;
      strobeHiPrev <= 1'b1;
    end else begin
      if (ageCnt != 2'd3) ageCnt <= ageCnt + 2'd1;
      strobeHiPrev <= progStrobeN;
    end
  end

  assign readNow    = !chipEnN && !outEnN && vppLevel == 2'd0 && a9Level == 2'd0;
  assign pvNow      = !chipEnN && !outEnN && progStrobeN && vppLevel == 2'd1 && a9Level == 2'd0;
  assign identNow   = !chipEnN && !outEnN && vppLevel == 2'd0 && a9Level == 2'd1;
  assign progPulse  = !chipEnN && outEnN && vppLevel == 2'd1 && a9Level == 2'd0 &&
                      !progStrobeN && strobeHiPrev;
  assign erasePulse = !chipEnN && outEnN && vppLevel == 2'd2 && a9Level == 2'd2 &&
                      addr == '0 && (&dataIn) && !progStrobeN && strobeHiPrev;

  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    chipEnN |-> (!dataDrive && !illegalCombo && dataOut == 8'h00));

  assert_read_steady_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ageCnt != 2'd0 && readNow && $past(readNow) && $stable(addr)) |-> $stable(dataOut));

  assert_prog_only_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ageCnt != 2'd0 && $past(progPulse) && pvNow && addr == $past(addr))
      |-> ((dataOut & ~$past(dataIn)) == 8'h00));

  assert_erase_blank_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ageCnt != 2'd0 && $past(erasePulse) && readNow) |-> (dataOut == 8'hFF));

  assert_ident_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    identNow |-> (dataDrive && dataOut == (addr[0] ? DEV_CODE : MFR_CODE)));

  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    illegalCombo |-> !dataDrive);

  assert_reserved_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEnN && (vppLevel == 2'd3 || a9Level == 2'd3)) |-> illegalCombo);
endmodule

bind eprom_mode_ctl eprom_mode_ctl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .chipEnN      (chipEnN),
  .outEnN       (outEnN),
  .progStrobeN  (progStrobeN),
  .addr         (addr),
  .dataIn       (dataIn),
  .vppLevel     (vppLevel),
  .a9Level      (a9Level),
  .dataOut      (dataOut),
  .dataDrive    (dataDrive),
  .illegalCombo (illegalCombo)
);

// File: tb/eprom_mode_ctl_tb_top.sv
`timescale 1ns/1ps
module eprom_mode_ctl_tb_top;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  localparam int M_STBY = 0, M_RD = 1, M_DIS = 2, M_PG = 3, M_PV = 4,
                 M_ER = 5, M_EV = 6, M_ID = 7, M_ILL = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              chipEnN = 1'b1, outEnN = 1'b1, progStrobeN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        dataIn = 8'h00;
  logic [1:0]        vppLevel = 2'd0, a9Level = 2'd0;
  logic [7:0]        dataOut;
  logic              dataDrive, illegalCombo;

  int  vecCnt = 0;
  int  errCnt = 0;
  bit  done = 1'b0;
  byte unsigned refMem [DEPTH];
  bit  refPrevHi = 1'b1;

  always #10 clk = ~clk;

  eprom_mode_ctl #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN),
    .progStrobeN(progStrobeN), .addr(addr), .dataIn(dataIn),
    .vppLevel(vppLevel), .a9Level(a9Level), .dataOut(dataOut),
    .dataDrive(dataDrive), .illegalCombo(illegalCombo)
  );

  // Reference mode classification from the requirement text
  function automatic int refMode();
    if (chipEnN) return M_STBY;
    if (vppLevel == 2'd3 || a9Level == 2'd3) return M_ILL;
    if (vppLevel == 2'd0) begin
      if (a9Level == 2'd2) return M_ILL;
      if (outEnN) return M_DIS;
      return (a9Level == 2'd1) ? M_ID : M_RD;
    end
    if (a9Level == 2'd1) return M_ILL;
    if (!outEnN) begin
      if (!progStrobeN) return M_ILL;
      if (vppLevel == 2'd1) return (a9Level == 2'd0) ? M_PV : M_ILL;
      return M_EV;
    end
    if (vppLevel == 2'd1) return (a9Level == 2'd0) ? M_PG : M_ILL;
    return (a9Level == 2'd2 && addr == '0 && dataIn == 8'hFF) ? M_ER : M_ILL;
  endfunction

  function automatic string modeTag(int m);
    case (m)
      M_STBY:       return "R2";
      M_RD, M_DIS:  return "R3";
      M_PG:         return "R4";
      M_PV:         return "R5";
      M_ER:         return "R6";
      M_EV:         return "R7";
      M_ID:         return "R8";
      default:      return "R9";
    endcase
  endfunction

  task automatic checkNow(input string tag);
    int m;
    logic expDrive, expIll;
    logic [7:0] expOut;
    string t;
    m = refMode();
    expDrive = (m == M_RD) || (m == M_PV) || (m == M_EV) || (m == M_ID);
    expIll   = (m == M_ILL);
    if (m == M_ID)     expOut = addr[0] ? 8'h01 : 8'hDA;
    else if (expDrive) expOut = refMem[addr];
    else               expOut = 8'h00;
    t = (tag.len() != 0) ? tag : modeTag(m);
    vecCnt++;
    if (dataDrive !== expDrive || dataOut !== expOut || illegalCombo !== expIll) begin
      errCnt++;
      $display("FAIL %s addr=%0d: drive=%0b out=%02h illegal=%0b, expected drive=%0b out=%02h illegal=%0b",
               t, addr, dataDrive, dataOut, illegalCombo, expDrive, expOut, expIll);
    end
  endtask

  // Model advance at a rising edge: write lands for the next cycle
  task automatic refStep();
    int m;
    bit fall;
    m = refMode();
    fall = refPrevHi && !progStrobeN;
    if (m == M_PG && fall) refMem[addr] = refMem[addr] & dataIn;
    if (m == M_ER && fall) for (int i = 0; i < DEPTH; i++) refMem[i] = 8'hFF;
    refPrevHi = progStrobeN;
  endtask

  task automatic apply(input logic ce, input logic oe, input logic pg,
                       input logic [ADDR_W-1:0] a, input logic [7:0] d,
                       input logic [1:0] vp, input logic [1:0] hv, input string tag);
    @(negedge clk);
    chipEnN = ce; outEnN = oe; progStrobeN = pg;
    addr = a; dataIn = d; vppLevel = vp; a9Level = hv;
    #5;
    checkNow(tag);
    @(posedge clk);
    refStep();
  endtask

  task automatic progByte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    apply(0, 1, 1, a, d, 2'd1, 2'd0, "R4");
    apply(0, 1, 0, a, d, 2'd1, 2'd0, "R4");
    apply(0, 1, 1, a, d, 2'd1, 2'd0, "R4");
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: blank array after reset
    for (int i = 0; i < DEPTH; i++) apply(0, 0, 1, ADDR_W'(i), 8'h00, 2'd0, 2'd0, "R1");
    // R3: output gate high turns the bus off
    apply(0, 1, 1, 4'd5, 8'h00, 2'd0, 2'd0, "R3");
    apply(0, 1, 1, 4'd6, 8'h00, 2'd0, 2'd1, "R3");

    // R4 / R5: program then check, second pulse ANDs
    progByte(4'd3, 8'h5A);
    apply(0, 0, 1, 4'd3, 8'h00, 2'd1, 2'd0, "R5");
    progByte(4'd3, 8'h0F);
    apply(0, 0, 1, 4'd3, 8'h00, 2'd1, 2'd0, "R4");
    progByte(4'd7, 8'h33);
    progByte(4'd15, 8'hC0);
    apply(0, 0, 1, 4'd7, 8'h00, 2'd1, 2'd0, "R5");
    apply(0, 0, 1, 4'd15, 8'h00, 2'd0, 2'd0, "R3");

    // R10: held strobe writes once
    apply(0, 1, 1, 4'd9, 8'hF0, 2'd1, 2'd0, "R10");
    apply(0, 1, 0, 4'd9, 8'hF0, 2'd1, 2'd0, "R10");
    apply(0, 1, 0, 4'd9, 8'h0F, 2'd1, 2'd0, "R10");
    apply(0, 1, 0, 4'd9, 8'h0F, 2'd1, 2'd0, "R10");
    apply(0, 0, 1, 4'd9, 8'h00, 2'd0, 2'd0, "R10");
    // R10: strobe already low when program mode is entered
    apply(0, 0, 0, 4'd10, 8'h00, 2'd0, 2'd0, "R10");
    apply(0, 1, 0, 4'd10, 8'h00, 2'd1, 2'd0, "R10");
    apply(0, 1, 0, 4'd10, 8'h00, 2'd1, 2'd0, "R10");
    apply(0, 0, 1, 4'd10, 8'h00, 2'd0, 2'd0, "R10");

    // R2: inhibit under program and erase levels
    apply(1, 1, 1, 4'd2, 8'h00, 2'd1, 2'd0, "R2");
    apply(1, 1, 0, 4'd2, 8'h00, 2'd1, 2'd0, "R2");
    apply(1, 1, 1, 4'd0, 8'hFF, 2'd2, 2'd2, "R2");
    apply(1, 1, 0, 4'd0, 8'hFF, 2'd2, 2'd2, "R2");
    apply(1, 0, 1, 4'd3, 8'h00, 2'd0, 2'd0, "R2");
    apply(0, 0, 1, 4'd2, 8'h00, 2'd0, 2'd0, "R2");
    apply(0, 0, 1, 4'd3, 8'h00, 2'd0, 2'd0, "R2");

    // R8: identifier codes
    apply(0, 0, 1, 4'd0, 8'h00, 2'd0, 2'd1, "R8");
    apply(0, 0, 1, 4'd1, 8'h00, 2'd0, 2'd1, "R8");
    apply(0, 0, 1, 4'd6, 8'h00, 2'd0, 2'd1, "R8");
    apply(0, 0, 0, 4'd7, 8'h00, 2'd0, 2'd1, "R8");

    // R9: illegal combinations, with strobe pulses, change nothing
    apply(0, 0, 1, 4'd3, 8'h00, 2'd3, 2'd0, "R9");
    apply(0, 1, 1, 4'd3, 8'h00, 2'd0, 2'd3, "R9");
    apply(0, 0, 1, 4'd3, 8'h00, 2'd0, 2'd2, "R9");
    apply(0, 1, 1, 4'd3, 8'h00, 2'd1, 2'd1, "R9");
    apply(0, 1, 0, 4'd3, 8'h00, 2'd1, 2'd1, "R9");
    apply(0, 0, 0, 4'd3, 8'h00, 2'd1, 2'd0, "R9");
    apply(0, 1, 1, 4'd1, 8'hFF, 2'd2, 2'd2, "R9");
    apply(0, 1, 0, 4'd1, 8'hFF, 2'd2, 2'd2, "R9");
    apply(0, 1, 1, 4'd0, 8'hFE, 2'd2, 2'd2, "R9");
    apply(0, 1, 0, 4'd0, 8'hFE, 2'd2, 2'd2, "R9");
    apply(0, 0, 1, 4'd3, 8'h00, 2'd0, 2'd0, "R9");

    // R6 / R7: bulk erase then check
    apply(0, 1, 1, 4'd0, 8'hFF, 2'd2, 2'd2, "R6");
    apply(0, 1, 0, 4'd0, 8'hFF, 2'd2, 2'd2, "R6");
    apply(0, 1, 1, 4'd0, 8'hFF, 2'd2, 2'd2, "R6");
    apply(0, 0, 1, 4'd3, 8'h00, 2'd2, 2'd2, "R7");
    apply(0, 0, 1, 4'd7, 8'h00, 2'd2, 2'd0, "R7");
    for (int i = 0; i < DEPTH; i++) apply(0, 0, 1, ADDR_W'(i), 8'h00, 2'd0, 2'd0, "R6");

    // Mixed stimulus; each compare is tagged by its expected mode
    for (int n = 0; n < 600; n++) begin
      apply(($urandom % 4) == 0, $urandom % 2, $urandom % 2,
            ADDR_W'($urandom), 8'($urandom), 2'($urandom), 2'($urandom % 3), "");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule